// File: doc/BRIEF.md
# Programmable-Latency Synchronous Burst Read Engine

This block is the read side of a memory that streams words in a clocked linear burst. A host pulses an address-valid strobe together with a start address. The word at that address is presented one cycle later, whatever the latency setting is. Each later word then appears after the programmed number of wait cycles, one word per clock. The word address advances automatically and wraps inside a fixed-size block.

A small configuration register sets the wait latency, the burst mode and an asynchronous-mode bit. In continuous mode the burst loops around its block indefinitely and only a reset ends it. An interrupt pulse marks each return to the start word. In fixed-length mode the burst ends after a preset number of words, with an interrupt pulse and a sticky completion flag. The host can read the configuration register in the middle of a burst; the stream pauses for that one cycle. A write strobe during a burst is refused and reported. When idle, the same strobe writes the storage array or the register.

The states are IDLE, FIRST (first word shown), WAIT (latency count) and STREAM (one word per cycle). The transitions are:
- IDLE→FIRST on a strobe to an array address.
- FIRST→IDLE when the asynchronous bit is set.
- FIRST→WAIT otherwise.
- WAIT→STREAM when the count expires.
- STREAM→IDLE after the last word of a fixed-length burst.

While a register read is in progress, no state moves.

Top module: `burst_read_engine`

## Requirements
- R1: The configuration register holds the latency in bits [2:0], the asynchronous-mode flag in bit 3 and fixed-length mode in bit 4. After reset it holds 4 (latency 4, continuous, synchronous). A written latency below 3 is stored as 3, so the latency always lies in 3..7.
- R2: The word at the start address appears on `dout` with `rdy` high in the cycle right after the strobe cycle, for every latency value.
- R3: Counting the strobe cycle as 0, word k (k ≥ 1) appears in cycle L+k, where L is the latency. `rdy` is high in that cycle and low in cycles 2..L, during which `dout` is 0.
- R4: Word k comes from address (start with its low 6 bits replaced by (start+k) mod 64). The upper address bits never change, so a burst wraps inside its 64-word block.
- R5: In continuous mode (bit 4 = 0) the burst never ends by itself. `irq` is high for exactly the cycles in which the word at the start address is shown again. `done_flag` stays 0, and only reset stops the stream.
- R6: In fixed-length mode (bit 4 = 1) the burst delivers 8 words. In the cycle after the last word, `rdy` is 0, `dout` is 0 and `irq` is high for one cycle. From then on `done_flag` is 1, until the next burst starts, when it returns to 0.
- R7: A strobe with address bit 8 set reads the register. In the next cycle `dout` holds the register value zero-extended and `rdy` is 0. A running burst pauses for that one cycle and then resumes with the next word, so no word is lost.
- R8: Driving `we_n` low while a burst runs makes `err` high in the next cycle for one cycle. The write is dropped: the array and the register keep their contents.
- R9: With the asynchronous flag set, an access still returns the correct first word with `rdy` high. The engine then returns to idle, with `rdy` low and `dout` 0.
- R10: Reset stops any burst at once. `rdy`, `irq`, `err`, `done_flag` and `dout` all go to 0.
- R11: When idle, `we_n` low with `adv` low writes `wdata` to the register if address bit 8 is set. Otherwise it writes `wdata` to the array word at address bits [7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Address-valid strobe: starts a burst or a register read |
| addr_in | input | 9 | Bit 8 selects the register; bits [7:0] give the array word |
| we_n | input | 1 | Active-low write strobe |
| wdata | input | 16 | Write data |
| dout | output | 16 | Burst data or register readback |
| rdy | output | 1 | High while `dout` carries a valid array word |
| irq | output | 1 | Wrap or completion pulse |
| done_flag | output | 1 | Sticky completion flag of a fixed-length burst |
| err | output | 1 | One-cycle pulse for a write refused during a burst |

## Verification
A wrong latency count or a stuck WAIT state shifts every word after the first. This shows on the first check after cycle L, well before the burst ends. A faulty address step or block wrap puts the wrong data on `dout` at word 1, or at the word that crosses the block edge. The random start addresses and the start address two words before the block end expose such a fault within a few words. A pause that drops or repeats a word appears in the cycle after a register read. A wrong mode decode appears as a missing or extra `irq`, or a `done_flag` that sets or clears in the wrong cycle.

// File: rtl/brst_pkg.sv
package brst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_WAIT,
        ST_STREAM
    } brst_state_t;

    localparam int unsigned LAT_MIN = 3;
    localparam int unsigned LAT_RST = 4;
endpackage

// File: rtl/brst_cfg.sv
module brst_cfg #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [4:0]    wbits,
    output logic [2:0]    lat,
    output logic          async_md,
    output logic          fixed_md,
    output logic [DW-1:0] cfg_word
);
    import brst_pkg::*;

    logic [2:0] lat_q;
    logic       async_q;
    logic       fixed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q   <= 3'(LAT_RST);
            async_q <= 1'b0;
            fixed_q <= 1'b0;
        end else if (wr) begin
            lat_q   <= (wbits[2:0] < 3'(LAT_MIN)) ? 3'(LAT_MIN) : wbits[2:0];
            async_q <= wbits[3];
            fixed_q <= wbits[4];
        end
    end

    assign lat      = lat_q;
    assign async_md = async_q;
    assign fixed_md = fixed_q;
    assign cfg_word = {{(DW-5){1'b0}}, fixed_q, async_q, lat_q};
endmodule

// File: rtl/brst_mem.sv
module brst_mem #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/brst_fsm.sv
module brst_fsm #(
    parameter int unsigned AW        = 8,
    parameter int unsigned BLK_WORDS = 64,
    parameter int unsigned FIX_LEN   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic                   is_reg,
    input  logic [AW-1:0]          start_addr,
    input  logic                   we_n,
    input  logic [2:0]             lat,
    input  logic                   async_md,
    input  logic                   fixed_md,
    output brst_pkg::brst_state_t  st,
    output logic                   hold,
    output logic [AW-1:0]          rd_addr,
    output logic                   wr_ok,
    output logic                   rdy,
    output logic                   irq,
    output logic                   done_flag,
    output logic                   err
);
    import brst_pkg::*;

    localparam int unsigned   CW       = $clog2(FIX_LEN + 1);
    localparam logic [AW-1:0] BLK_MASK = AW'(BLK_WORDS - 1);

    brst_state_t   st_nx;
    logic [AW-1:0] cur;
    logic [AW-1:0] start_q;
    logic [2:0]    cnt;
    logic [CW-1:0] rem;
    logic          idle;
    logic          burst_go;
    logic          last_fix;
    logic          wrap_hit;

    function automatic logic [AW-1:0] winc(input logic [AW-1:0] a);
        return (a & ~BLK_MASK) | ((a + 1'b1) & BLK_MASK);
    endfunction

    assign idle     = (st == ST_IDLE);
    assign burst_go = idle && adv && !is_reg && !hold;
    assign last_fix = (st == ST_STREAM) && fixed_md && (rem == CW'(1));
    assign wrap_hit = (st == ST_STREAM) && !fixed_md && (winc(cur) == start_q);
    assign wr_ok    = idle && !we_n && !adv;

    always_comb begin
        st_nx = st;
        if (!hold) begin
            unique case (st)
                ST_IDLE:   if (burst_go) st_nx = ST_FIRST;
                ST_FIRST:  st_nx = async_md ? ST_IDLE : ST_WAIT;
                ST_WAIT:   if (cnt == 3'd0) st_nx = ST_STREAM;
                ST_STREAM: if (last_fix) st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        rd_addr = cur;
        if (!hold) begin
            unique case (st)
                ST_IDLE:   rd_addr = start_addr;
                ST_FIRST:  rd_addr = winc(cur);
                ST_WAIT:   rd_addr = cur;
                ST_STREAM: rd_addr = winc(cur);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            start_q <= '0;
            cnt     <= '0;
            rem     <= '0;
        end else if (!hold) begin
            unique case (st)
                ST_IDLE: begin
                    if (burst_go) begin
                        cur     <= start_addr;
                        start_q <= start_addr;
                    end
                end
                ST_FIRST: begin
                    cur <= winc(cur);
                    cnt <= lat - 3'd2;
                    rem <= CW'(FIX_LEN - 1);
                end
                ST_WAIT: begin
                    if (cnt != 3'd0) cnt <= cnt - 3'd1;
                end
                ST_STREAM: begin
                    cur <= winc(cur);
                    rem <= rem - CW'(1);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold      <= 1'b0;
            irq       <= 1'b0;
            done_flag <= 1'b0;
            err       <= 1'b0;
        end else begin
            hold <= adv && is_reg;
            irq  <= !hold && (last_fix || wrap_hit);
            err  <= !we_n && !idle;
            if (burst_go) begin
                done_flag <= 1'b0;
            end else if (!hold && last_fix) begin
                done_flag <= 1'b1;
            end
        end
    end

    always_comb begin
        rdy = !hold && ((st == ST_FIRST) || (st == ST_STREAM));
    end
endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine #(
    parameter int unsigned DW        = 16,
    parameter int unsigned ARR_AW    = 8,
    parameter int unsigned BLK_WORDS = 64,
    parameter int unsigned FIX_LEN   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [ARR_AW:0] addr_in,
    input  logic            we_n,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   dout,
    output logic            rdy,
    output logic            irq,
    output logic            done_flag,
    output logic            err
);
    import brst_pkg::*;

    brst_state_t     st;
    logic            hold;
    logic            is_reg;
    logic            wr_ok;
    logic [2:0]      lat;
    logic            async_md;
    logic            fixed_md;
    logic [DW-1:0]   cfg_word;
    logic [DW-1:0]   rdata;
    logic [ARR_AW-1:0] rd_addr;

    assign is_reg = addr_in[ARR_AW];

    brst_cfg #(.DW(DW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_ok && is_reg),
        .wbits    (wdata[4:0]),
        .lat      (lat),
        .async_md (async_md),
        .fixed_md (fixed_md),
        .cfg_word (cfg_word)
    );

    brst_mem #(.DW(DW), .AW(ARR_AW)) u_mem (
        .clk   (clk),
        .we    (wr_ok && !is_reg),
        .waddr (addr_in[ARR_AW-1:0]),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    brst_fsm #(.AW(ARR_AW), .BLK_WORDS(BLK_WORDS), .FIX_LEN(FIX_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .is_reg     (is_reg),
        .start_addr (addr_in[ARR_AW-1:0]),
        .we_n       (we_n),
        .lat        (lat),
        .async_md   (async_md),
        .fixed_md   (fixed_md),
        .st         (st),
        .hold       (hold),
        .rd_addr    (rd_addr),
        .wr_ok      (wr_ok),
        .rdy        (rdy),
        .irq        (irq),
        .done_flag  (done_flag),
        .err        (err)
    );

    always_comb begin
        if (hold) begin
            dout = cfg_word;
        end else if (rdy) begin
            dout = rdata;
        end else begin
            dout = '0;
        end
    end
endmodule

// File: rtl/brst_chk.sv
module brst_chk #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  adv,
    input logic [AW-1:0]         addr_in,
    input logic                  we_n,
    input brst_pkg::brst_state_t st,
    input logic                  hold,
    input logic [2:0]            lat,
    input logic                  rdy,
    input logic                  irq,
    input logic                  err,
    input logic                  done_flag,
    input logic [DW-1:0]         dout,
    input logic [DW-1:0]         cfg_word
);
    import brst_pkg::*;

    AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (lat >= 3'd3) && (lat <= 3'd7));                                   // R1
    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && adv && !addr_in[AW-1] && !hold) |=> rdy);       // R2
    AST_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && addr_in[AW-1]) |=> (!rdy && dout == cfg_word));            // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && st != ST_IDLE) |=> err);                                 // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                     // R6
    AST_DONE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> irq);                                         // R6
endmodule

bind burst_read_engine brst_chk #(.DW(DW), .AW(ARR_AW + 1)) u_brst_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .addr_in   (addr_in),
    .we_n      (we_n),
    .st        (st),
    .hold      (hold),
    .lat       (lat),
    .rdy       (rdy),
    .irq       (irq),
    .err       (err),
    .done_flag (done_flag),
    .dout      (dout),
    .cfg_word  (cfg_word)
);

// File: tb/test_burst_read_engine.sv
module test_burst_read_engine;
    localparam int FIXN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0;
    logic [8:0]  addr = '0;
    logic        we_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] dout;
    logic        rdy, irq, done_flag, err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    burst_read_engine i_burst_read_engine (
        .clk(clk), .rst_n(rst_n), .adv(adv), .addr_in(addr), .we_n(we_n),
        .wdata(wdata), .dout(dout), .rdy(rdy), .irq(irq),
        .done_flag(done_flag), .err(err)
    );

    function automatic logic [15:0] memv(input logic [7:0] a);
        return (16'(a) * 16'd613) ^ 16'h5A3C;
    endfunction

    function automatic logic [7:0] wrapk(input logic [7:0] s, input int k);
        logic [7:0] sum;
        sum = s + 8'(k);
        return (s & 8'hC0) | (sum & 8'h3F);
    endfunction

    function automatic int efflat(input int raw);
        return (raw < 3) ? 3 : raw;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        addr = a; wdata = d; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
    endtask

    task automatic rd_reg(input string req, input logic [15:0] exp);
        adv = 1'b1; addr = 9'h100;
        @(negedge clk);
        adv = 1'b0;
        chk(req, dout, exp);
        chk(req, rdy, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; adv = 1'b0; we_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // full burst check from strobe to last word (or one past it in fixed mode)
    task automatic run_burst(input logic [7:0] s, input int raw, input bit fixed, input int nw);
        int l;
        int k;
        l = efflat(raw);
        wr(9'h100, {11'b0, fixed, 1'b0, 3'(raw)});
        adv = 1'b1; addr = {1'b0, s};
        @(negedge clk);
        adv = 1'b0;
        chk("R2 first word", dout, memv(s));
        chk("R2 first rdy", rdy, 1);
        chk("R6 done cleared", done_flag, 0);
        for (int t = 2; t <= l + nw; t++) begin
            @(negedge clk);
            k = t - l;
            if (k < 1) begin
                chk("R3 wait rdy", rdy, 0);
                chk("R3 wait dout", dout, 0);
            end else if (fixed && k >= FIXN) begin
                chk("R6 end rdy", rdy, 0);
                chk("R6 end dout", dout, 0);
                chk("R6 irq", irq, 1);
                chk("R6 done", done_flag, 1);
            end else begin
                chk("R3 word rdy", rdy, 1);
                chk("R4 word data", dout, memv(wrapk(s, k)));
                chk("R5 irq", irq, (!fixed && k % 64 == 0) ? 1 : 0);
            end
        end
        if (fixed) begin
            @(negedge clk);
            chk("R6 irq single", irq, 0);
            chk("R6 done held", done_flag, 1);
        end else begin
            chk("R5 no done", done_flag, 0);
            do_reset();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rdy", rdy, 0);
        chk("R10 irq", irq, 0);
        chk("R10 err", err, 0);
        chk("R10 done", done_flag, 0);
        chk("R10 dout", dout, 0);
        rd_reg("R1 reset value", 16'd4);

        // R11 fill array through idle writes
        for (int a = 0; a < 256; a++) wr({1'b0, 8'(a)}, memv(8'(a)));
        wr(9'h100, 16'h0001);
        rd_reg("R1 clamp to 3", 16'd3);
        wr(9'h100, 16'h0016);
        rd_reg("R11 reg write", 16'h0016);

        // R3 R4 R5: every latency, start two words before block end
        for (int l = 3; l <= 7; l++) run_burst(8'd62, l, 1'b0, 70);
        // R6 fixed bursts crossing the block edge
        run_burst(8'd125, 3, 1'b1, FIXN);
        run_burst(8'd60, 7, 1'b1, FIXN);

        // R7 register read during a stream: no word lost
        wr(9'h100, 16'h0003);
        adv = 1'b1; addr = 9'd10;
        @(negedge clk); adv = 1'b0;
        for (int t = 2; t <= 5; t++) @(negedge clk);
        chk("R7 before read", dout, memv(8'd12));
        adv = 1'b1; addr = 9'h100;
        @(negedge clk); adv = 1'b0;
        chk("R7 readback", dout, 16'd3);
        chk("R7 paused rdy", rdy, 0);
        @(negedge clk);
        chk("R7 resume", dout, memv(8'd13));
        @(negedge clk);
        chk("R7 next", dout, memv(8'd14));

        // R8 writes during the burst are refused
        wr(9'h100, 16'h0017);
        chk("R8 err pulse", err, 1);
        @(negedge clk);
        chk("R8 err single", err, 0);
        wr(9'd200, 16'hDEAD);
        chk("R8 err array", err, 1);
        rd_reg("R8 reg unchanged", 16'd3);
        do_reset();
        run_burst(8'd200, 4, 1'b1, FIXN);

        // R9 asynchronous mode: first word only
        wr(9'h100, 16'h000D);
        adv = 1'b1; addr = 9'd100;
        @(negedge clk); adv = 1'b0;
        chk("R9 first word", dout, memv(8'd100));
        chk("R9 first rdy", rdy, 1);
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            chk("R9 idle rdy", rdy, 0);
            chk("R9 idle dout", dout, 0);
        end

        // R10 reset in the middle of a fixed burst
        wr(9'h100, 16'h0013);
        adv = 1'b1; addr = 9'd33;
        @(negedge clk); adv = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R10 mid rdy", rdy, 0);
        chk("R10 mid dout", dout, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 mid irq", irq, 0);
        rd_reg("R10 reg default", 16'd4);

        // random bursts
        for (int i = 0; i < 14; i++) begin
            logic [7:0] s;
            int raw;
            bit fx;
            s   = 8'($urandom % 256);
            raw = int'($urandom % 8);
            fx  = 1'($urandom % 2);
            run_burst(s, raw, fx, fx ? FIXN : 20 + int'($urandom % 60));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule